// File: doc/BRIEF.md
# Manchester Line Transmitter with Leading Sync Zero

This block sends one data word at a time as a Manchester-coded serial line. Inside it, a shift register behaves like an SPI mode 0 master: an internal bit clock idles low, rises halfway through each bit and falls at the end of the bit. The shifted data changes only on that falling edge. The line output is the current data bit XORed with the bit clock. A logical one therefore drives high and then low, and a logical zero drives low and then high. Every bit has a transition in its middle that a receiver can lock onto.

Each frame starts with one fixed zero bit. This bit lets a receiver find the mid-bit edge before the payload begins. The payload word follows, most significant bit first by default. Each half of a bit lasts `HALF_BIT_CYCLES` system clocks. A word is offered with a valid/ready handshake. While a frame is on the line the block reports busy and holds ready low. When the last half-bit ends, it raises a one-clock done pulse.

Top module: `manch_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `line_o` is 0, `busy_o` is 0, `in_ready` is 1 and `done_o` is 0.
- R2: A payload bit of value 1 appears on `line_o` as 1 for the first half of its bit slot and 0 for the second half.
- R3: A payload bit of value 0 appears on `line_o` as 0 for the first half of its bit slot and 1 for the second half.
- R4: Each half-bit lasts exactly `HALF_BIT_CYCLES` clocks. A frame keeps `busy_o` high for exactly 2*(DATA_W+1)*HALF_BIT_CYCLES clocks, starting the cycle after the accepting edge.
- R5: The first bit slot of every frame is a sync zero: 0 for one half-bit, then 1 for one half-bit, whatever the payload.
- R6: With the default order, payload bits follow the sync slot from bit DATA_W-1 down to bit 0. For example, 0x34 is sent as 0,0,1,1,0,1,0,0.
- R7: A word is accepted on a clock edge where `in_valid` and `in_ready` are both 1, and `in_ready` is 0 throughout a frame. A word offered while busy is ignored and does not change the frame in progress.
- R8: `done_o` is high for exactly one clock, in the cycle right after the last half-bit ends, which is also the first cycle with `busy_o` low.
- R9: A word offered during the done cycle starts a new frame on the next edge. The line is 0 for that one cycle between the frames.
- R10: Asserting reset in the middle of a frame aborts it: on the next sample `line_o` and `busy_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A payload word is offered |
| in_ready | output | 1 | Block can accept a word (not busy) |
| in_data | input | DATA_W | Payload word |
| line_o | output | 1 | Manchester-coded line |
| busy_o | output | 1 | A frame is on the line |
| done_o | output | 1 | One-clock pulse after the final half-bit |

## Verification
The hardest condition to create from the ports is a word arriving in the single done cycle, right at the frame boundary. The bench raises `in_valid` during the last half-bit of a frame. The first edge where `in_ready` returns then accepts the new word, and the bench checks the one-cycle low gap and the next frame's sync slot. The bench also holds `in_valid` high with a different word through most of a frame, to show that the data offered while busy never reaches the line.

// File: rtl/manch_pkg.sv
package manch_pkg;

   typedef enum logic {
      ORDER_LSB = 1'b0,
      ORDER_MSB = 1'b1
   } bit_order_e;

   // sync slot plus payload
   function automatic int frame_bits(input int data_w);
      return data_w + 1;
   endfunction

endpackage

// File: rtl/manch_half_timer.sv
module manch_half_timer #(
   parameter int HALF_BIT_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   output logic tick
);
   localparam int CNT_W = (HALF_BIT_CYCLES > 2) ? $clog2(HALF_BIT_CYCLES) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_BIT_CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart || !run) begin
         cnt_q <= '0;
      end else if (cnt_q == CNT_LAST) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign tick = run && (cnt_q == CNT_LAST);

endmodule

// File: rtl/manch_phase_seq.sv
module manch_phase_seq #(
   parameter int NBITS = 9
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic tick,
   output logic bit_clk,
   output logic busy,
   output logic done,
   output logic advance,
   output logic finish
);
   localparam int IDX_W = $clog2(NBITS + 1);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NBITS - 1);

   logic [IDX_W-1:0] idx_q;
   logic             end_of_bit;

   assign end_of_bit = busy && tick && bit_clk;
   assign advance    = end_of_bit && (idx_q != IDX_LAST);
   assign finish     = end_of_bit && (idx_q == IDX_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         bit_clk <= 1'b0;
         done    <= 1'b0;
         idx_q   <= '0;
      end else begin
         done <= 1'b0;
         if (start) begin
            busy    <= 1'b1;
            bit_clk <= 1'b0;
            idx_q   <= '0;
         end else if (busy && tick) begin
            if (!bit_clk) begin
               bit_clk <= 1'b1;
            end else begin
               bit_clk <= 1'b0;
               if (finish) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
         end
      end
   end

endmodule

// File: rtl/manch_shift_reg.sv
module manch_shift_reg
   import manch_pkg::*;
#(
   parameter int         DATA_W = 8,
   parameter bit_order_e ORDER  = ORDER_MSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              shift,
   input  logic              clear,
   output logic              bit_o
);
   localparam int NBITS = frame_bits(DATA_W);

   logic [NBITS-1:0] sr_q;

   generate
      if (ORDER == ORDER_MSB) begin : g_msb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      sr_q <= '0;
            else if (load)   sr_q <= {1'b0, load_data};
            else if (clear)  sr_q <= '0;
            else if (shift)  sr_q <= {sr_q[NBITS-2:0], 1'b0};
         end
         assign bit_o = sr_q[NBITS-1];
      end else begin : g_lsb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      sr_q <= '0;
            else if (load)   sr_q <= {load_data, 1'b0};
            else if (clear)  sr_q <= '0;
            else if (shift)  sr_q <= {1'b0, sr_q[NBITS-1:1]};
         end
         assign bit_o = sr_q[0];
      end
   endgenerate

endmodule

// File: rtl/manch_tx.sv
module manch_tx
   import manch_pkg::*;
#(
   parameter int         DATA_W          = 8,
   parameter int         HALF_BIT_CYCLES = 4,
   parameter bit_order_e ORDER           = ORDER_MSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   output logic              line_o,
   output logic              busy_o,
   output logic              done_o
);
   localparam int NBITS = frame_bits(DATA_W);

   initial begin
      assert (HALF_BIT_CYCLES >= 2) else $fatal(1, "HALF_BIT_CYCLES must be at least 2");
      assert (DATA_W >= 1)          else $fatal(1, "DATA_W must be at least 1");
   end

   logic accept, tick, bit_clk, busy, done, advance, finish, data_bit;

   assign in_ready = !busy;
   assign accept   = in_valid && in_ready;

   manch_half_timer #(.HALF_BIT_CYCLES(HALF_BIT_CYCLES)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (busy),
      .restart (accept),
      .tick    (tick)
   );

   manch_phase_seq #(.NBITS(NBITS)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (accept),
      .tick    (tick),
      .bit_clk (bit_clk),
      .busy    (busy),
      .done    (done),
      .advance (advance),
      .finish  (finish)
   );

   manch_shift_reg #(.DATA_W(DATA_W), .ORDER(ORDER)) u_sr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .load_data (in_data),
      .shift     (advance),
      .clear     (finish),
      .bit_o     (data_bit)
   );

   assign line_o = data_bit ^ bit_clk;
   assign busy_o = busy;
   assign done_o = done;

endmodule

// File: rtl/manch_tx_chk.sv
module manch_tx_chk #(
   parameter int DATA_W          = 8,
   parameter int HALF_BIT_CYCLES = 4
) (
   input logic clk,
   input logic rst_n,
   input logic in_valid,
   input logic in_ready,
   input logic line_o,
   input logic busy_o,
   input logic done_o
);
   localparam int BIT_CYC = 2 * HALF_BIT_CYCLES;

   logic [15:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  run_cnt <= '0;
      else if (in_valid && in_ready) run_cnt <= '0;
      else if (busy_o)             run_cnt <= run_cnt + 1'b1;
   end

   assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !line_o);

   assert_mid_bit_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o) && (int'(run_cnt) % BIT_CYC == HALF_BIT_CYCLES))
      |-> (line_o != $past(line_o)));

   assert_edge_on_half_grid_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o) && (line_o != $past(line_o)))
      |-> (int'(run_cnt) % HALF_BIT_CYCLES == 0));

   assert_sync_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && (int'(run_cnt) < HALF_BIT_CYCLES)) |-> !line_o);

   assert_accept_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> busy_o);

   assert_done_after_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o)));

   assert_done_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);

endmodule

bind manch_tx manch_tx_chk #(
   .DATA_W          (DATA_W),
   .HALF_BIT_CYCLES (HALF_BIT_CYCLES)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .line_o   (line_o),
   .busy_o   (busy_o),
   .done_o   (done_o)
);

// File: tb/manch_tx_tb_top.sv
module manch_tx_tb_top;
   localparam int DW    = 8;
   localparam int H     = 3;
   localparam int NBITS = DW + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic          in_ready, line_o, busy_o, done_o;
   int            n_chk = 0;
   int            n_err = 0;

   always #5 clk = ~clk;

   manch_tx #(.DATA_W(DW), .HALF_BIT_CYCLES(H)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .line_o(line_o), .busy_o(busy_o), .done_o(done_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
      end
   endtask

   // Offer a word at a negedge; leaves the bench at the negedge of half 0, cycle 0.
   task automatic offer(input logic [DW-1:0] b);
      @(negedge clk);
      in_data  = b;
      in_valid = 1'b1;
      chk(in_ready == 1'b1, "R7 ready before offer", int'(in_ready), 1);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // mode 0: plain, 1: offer other data while busy, 2: offer next word at last half
   task automatic watch(input logic [DW-1:0] b, input int mode, input logic [DW-1:0] nb);
      for (int k = 0; k < 2 * NBITS; k++) begin
         for (int c = 0; c < H; c++) begin
            logic bv, ev;
            string req;
            if (k != 0 || c != 0) @(negedge clk);
            if (k == 0 && c == 0) chk(done_o == 1'b0, "R8 done low in frame", int'(done_o), 0);
            bv  = (k / 2 == 0) ? 1'b0 : b[DW - k / 2];
            ev  = (k % 2 == 0) ? bv : ~bv;
            req = (k / 2 == 0) ? "R5 sync" : (bv ? "R2/R6 one" : "R3/R6 zero");
            chk(line_o == ev, req, int'(line_o), int'(ev));
            chk(busy_o == 1'b1, "R4 busy in frame", int'(busy_o), 1);
            if (mode == 1 && k == 2 && c == 0) begin
               in_data  = ~b;
               in_valid = 1'b1;
            end
            if (mode == 1 && k >= 2 && k < 2 * NBITS - 2)
               chk(in_ready == 1'b0, "R7 ready low while busy", int'(in_ready), 0);
            if (mode == 1 && k == 2 * NBITS - 2 && c == 0) in_valid = 1'b0;
            if (mode == 2 && k == 2 * NBITS - 1 && c == 0) begin
               in_data  = nb;
               in_valid = 1'b1;
            end
         end
      end
      @(negedge clk);
      chk(done_o == 1'b1, "R8 done pulse", int'(done_o), 1);
      chk(busy_o == 1'b0, "R4 busy ends", int'(busy_o), 0);
      chk(line_o == 1'b0, "R9 gap low", int'(line_o), 0);
      if (mode == 2) begin
         chk(in_ready == 1'b1, "R9 ready in done cycle", int'(in_ready), 1);
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk(line_o == 1'b0, "R1 line", int'(line_o), 0);
      chk(busy_o == 1'b0, "R1 busy", int'(busy_o), 0);
      chk(in_ready == 1'b1, "R1 ready", int'(in_ready), 1);
      chk(done_o == 1'b0, "R1 done", int'(done_o), 0);
   endtask

   task automatic t_frame(input logic [DW-1:0] b);
      offer(b);
      watch(b, 0, '0);
      @(negedge clk);
      chk(done_o == 1'b0, "R8 done one cycle", int'(done_o), 0);
      chk(line_o == 1'b0, "R1 idle line", int'(line_o), 0);
   endtask

   task automatic t_ignore_busy(input logic [DW-1:0] b);
      offer(b);
      watch(b, 1, '0);
      @(negedge clk);
      chk(busy_o == 1'b0, "R7 no second frame", int'(busy_o), 0);
   endtask

   task automatic t_back_to_back(input logic [DW-1:0] a, input logic [DW-1:0] b);
      offer(a);
      watch(a, 2, b);
      watch(b, 0, '0);
      @(negedge clk);
   endtask

   task automatic t_reset_mid;
      offer(8'hFF);
      repeat (5 * H) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(line_o == 1'b0, "R10 line after reset", int'(line_o), 0);
      chk(busy_o == 1'b0, "R10 busy after reset", int'(busy_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(in_ready == 1'b1, "R10 ready after reset", int'(in_ready), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_frame(8'h34);
      t_frame(8'hFF);
      t_frame(8'h00);
      t_frame(8'hA5);
      t_ignore_busy(8'h5A);
      t_back_to_back(8'hC3, 8'h81);
      t_reset_mid();
      t_frame(8'h7E);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule